// File: doc/BRIEF.md
# Oscillator Configuration Register Interface

This block is a memory-mapped slave on a simple 32-bit register bus. It stands in for a board system-configuration channel. Software first writes a data word, then writes a command word. The command word names a board controller, a site, a position, a function and a device, and carries a start bit that launches the request.

Only oscillator reads are serviced. For those, the block looks up a fixed clock frequency for the addressed site and device and loads it into the shared data register. Software then reads the result back from that register. Configuration writes are accepted and change nothing.

A status register always reports completion, and the command register always reads as not busy. Two observation outputs show that a request was decoded and whether its target was known.

Top module: `osc_cfg_regs`

## Requirements
- R1: After reset the data register reads 0, and `rd_data_o`, `req_pulse_o` and `unknown_o` are 0.
- R2: The data register sits at offset 0xA0. A write there stores the full 32-bit word, and a later read at 0xA0 returns it.
- R3: A read at 0xA8 (status) returns 1, a read at 0xA4 (command) returns 0, and a read at any other offset returns 0.
- R4: The command word at 0xA4 is laid out as follows: device in bits 11:0, position in bits 15:12, site in bits 17:16, function in bits 25:20, controller in bits 29:26, write flag in bit 30, start in bit 31. A command write with bit 31 clear leaves the data register unchanged, leaves `unknown_o` unchanged and gives no pulse.
- R5: A started command with bit 30 set leaves the data register unchanged and clears `unknown_o`.
- R6: A started read whose controller is not 0, whose position is not 0, or whose function is not 1 leaves the data register unchanged and sets `unknown_o`.
- R7: A serviced read for site 0 loads 25000000 for device 0, 25000000 for device 1 and 24000000 for device 2. Any other device loads 0 and sets `unknown_o`.
- R8: A serviced read for site 1 loads the following values. Any other device loads 0 and sets `unknown_o`.
  - device 0: 50000000
  - device 4: 40000000
  - device 5: 50000000
  - device 6: 35000000
  - devices 7 and 8: 40000000
- R9: A serviced read for site 2 or 3 leaves the data register unchanged and sets `unknown_o`. A serviced read that hits a known device clears `unknown_o`.
- R10: Writes to the status offset or to unmapped offsets change no register.
- R11: `rd_data_o` is registered. It carries the value addressed by a read on the cycle after `rd_en_i`, and holds its value otherwise. A command's lookup result is visible to the first data read issued after the command write.
- R12: `req_pulse_o` is high for exactly the one cycle after each command write with bit 31 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte offset of the register access |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| req_pulse_o | output | 1 | One-cycle pulse per started command |
| unknown_o | output | 1 | Last started command missed a known target |

## Verification
Random command words are biased toward the serviced case, with devices drawn just past each site's mapped range. This exposes lookup tables with a missing entry or a wrong fallback value. Started commands on sites 2 and 3 catch a design that zeroes the data register instead of leaving it alone. Commands with the write flag set, or with the start bit clear, catch a design that runs the lookup anyway. Reads at the status and command offsets, and writes to the status and unmapped offsets, catch an offset decoder that aliases them onto the data register.

// File: rtl/osc_cfg_pkg.sv
package osc_cfg_pkg;
  localparam int unsigned DATA_W = 32;

  typedef struct packed {
    logic        start;
    logic        wr;
    logic [3:0]  ctl;
    logic [5:0]  fn;
    logic [1:0]  rsvd;
    logic [1:0]  site;
    logic [3:0]  pos;
    logic [11:0] dev;
  } cfg_cmd_t;

  localparam logic [5:0] FN_OSC = 6'd1;

  localparam logic [DATA_W-1:0] F_25M = 32'd25000000;
  localparam logic [DATA_W-1:0] F_24M = 32'd24000000;
  localparam logic [DATA_W-1:0] F_50M = 32'd50000000;
  localparam logic [DATA_W-1:0] F_40M = 32'd40000000;
  localparam logic [DATA_W-1:0] F_35M = 32'd35000000;
endpackage

// File: rtl/osc_freq_lut.sv
module osc_freq_lut
  import osc_cfg_pkg::*;
(
  input  logic [1:0]        site_i,
  input  logic [11:0]       dev_i,
  output logic [DATA_W-1:0] freq_o,
  output logic              site_hit_o,
  output logic              dev_hit_o
);
  always_comb begin
    freq_o     = '0;
    site_hit_o = 1'b0;
    dev_hit_o  = 1'b0;
    unique case (site_i)
      2'd0: begin
        site_hit_o = 1'b1;
        dev_hit_o  = 1'b1;
        case (dev_i)
          12'd0:   freq_o = F_25M;
          12'd1:   freq_o = F_25M;
          12'd2:   freq_o = F_24M;
          default: dev_hit_o = 1'b0;
        endcase
      end
      2'd1: begin
        site_hit_o = 1'b1;
        dev_hit_o  = 1'b1;
        case (dev_i)
          12'd0:   freq_o = F_50M;
          12'd4:   freq_o = F_40M;
          12'd5:   freq_o = F_50M;
          12'd6:   freq_o = F_35M;
          12'd7:   freq_o = F_40M;
          12'd8:   freq_o = F_40M;
          default: dev_hit_o = 1'b0;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/osc_cmd_decode.sv
module osc_cmd_decode
  import osc_cfg_pkg::*;
(
  input  logic              cmd_we_i,
  input  logic [DATA_W-1:0] cmd_i,
  output logic              started_o,
  output logic              load_o,
  output logic [DATA_W-1:0] load_val_o,
  output logic              unknown_o
);
  cfg_cmd_t cmd;
  logic [DATA_W-1:0] freq;
  logic site_hit, dev_hit, is_osc_rd;

  assign cmd = cfg_cmd_t'(cmd_i);

  osc_freq_lut u_lut (
    .site_i    (cmd.site),
    .dev_i     (cmd.dev),
    .freq_o    (freq),
    .site_hit_o(site_hit),
    .dev_hit_o (dev_hit)
  );

  assign started_o  = cmd_we_i && cmd.start;
  assign is_osc_rd  = !cmd.wr && (cmd.ctl == '0) && (cmd.pos == '0) && (cmd.fn == FN_OSC);
  // unmapped site leaves data alone; unmapped device on a known site loads 0
  assign load_o     = started_o && is_osc_rd && site_hit;
  assign load_val_o = freq;
  assign unknown_o  = !cmd.wr && !(is_osc_rd && site_hit && dev_hit);
endmodule

// File: rtl/osc_cfg_regs.sv
module osc_cfg_regs
  import osc_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] OFF_DATA = 8'hA0,
  parameter logic [ADDR_W-1:0] OFF_CMD  = 8'hA4,
  parameter logic [ADDR_W-1:0] OFF_STAT = 8'hA8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  input  logic              rd_en_i,
  output logic [31:0]       rd_data_o,
  output logic              req_pulse_o,
  output logic              unknown_o
);
  localparam logic [DATA_W-1:0] STAT_DONE = DATA_W'(1);

  logic [DATA_W-1:0] data_q, rd_mux, load_val;
  logic cmd_we, started, load, unk_d;

  assign cmd_we = wr_en_i && (addr_i == OFF_CMD);

  osc_cmd_decode u_dec (
    .cmd_we_i  (cmd_we),
    .cmd_i     (wr_data_i),
    .started_o (started),
    .load_o    (load),
    .load_val_o(load_val),
    .unknown_o (unk_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (wr_en_i && addr_i == OFF_DATA) begin
      data_q <= wr_data_i;
    end else if (load) begin
      data_q <= load_val;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_pulse_o <= 1'b0;
      unknown_o   <= 1'b0;
    end else begin
      req_pulse_o <= started;
      if (started) unknown_o <= unk_d;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == OFF_DATA)      rd_mux = data_q;
    else if (addr_i == OFF_STAT) rd_mux = STAT_DONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_mux;
  end
endmodule

// File: rtl/osc_cfg_regs_chk.sv
module osc_cfg_regs_chk #(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] OFF_DATA = 8'hA0,
  parameter logic [ADDR_W-1:0] OFF_CMD  = 8'hA4,
  parameter logic [ADDR_W-1:0] OFF_STAT = 8'hA8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [31:0]       wr_data_i,
  input logic              rd_en_i,
  input logic [31:0]       rd_data_o,
  input logic              req_pulse_o,
  input logic              unknown_o,
  input logic [31:0]       data_q
);
  // R12
  pulse_on_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_CMD && wr_data_i[31]) |=> req_pulse_o);
  // R12
  no_spurious_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == OFF_CMD && wr_data_i[31]) |=> !req_pulse_o);
  // R4
  idle_cmd_keeps_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_CMD && !wr_data_i[31]) |=> ($stable(data_q) && $stable(unknown_o)));
  // R5
  cfg_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_CMD && wr_data_i[31] && wr_data_i[30]) |=> ($stable(data_q) && !unknown_o));
  // R3
  stat_reads_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFF_STAT) |=> (rd_data_o == 32'd1));
  // R10
  stat_write_dropped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_STAT) |=> $stable(data_q));
  // R11
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

bind osc_cfg_regs osc_cfg_regs_chk #(
  .ADDR_W(ADDR_W), .OFF_DATA(OFF_DATA), .OFF_CMD(OFF_CMD), .OFF_STAT(OFF_STAT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .rd_en_i    (rd_en_i),
  .rd_data_o  (rd_data_o),
  .req_pulse_o(req_pulse_o),
  .unknown_o  (unknown_o),
  .data_q     (data_q)
);

// File: tb/osc_cfg_regs_tb.sv
module osc_cfg_regs_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        rd_en_i = 1'b0;
  logic [31:0] rd_data_o;
  logic        req_pulse_o, unknown_o;

  int unsigned n_chk = 0, n_err = 0;
  logic [31:0] m_data = '0;
  logic        m_unk = 1'b0;
  logic        done = 1'b0;

  always #2 clk_i = ~clk_i;

  osc_cfg_regs u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] freq_of(input logic [1:0] site, input logic [11:0] dev);
    // {known_device, value}
    if (site == 2'd0) begin
      if (dev == 0 || dev == 1) return {1'b1, 32'd25000000};
      if (dev == 2) return {1'b1, 32'd24000000};
      return {1'b0, 32'd0};
    end
    if (dev == 0 || dev == 5) return {1'b1, 32'd50000000};
    if (dev == 4 || dev == 7 || dev == 8) return {1'b1, 32'd40000000};
    if (dev == 6) return {1'b1, 32'd35000000};
    return {1'b0, 32'd0};
  endfunction

  function automatic logic [31:0] mk_cmd(input bit st, input bit wr, input logic [3:0] ctl,
      input logic [5:0] fn, input logic [1:0] site, input logic [3:0] pos, input logic [11:0] dev);
    return {st, wr, ctl, fn, 2'b00, site, pos, dev};
  endfunction

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input string req);
    @(negedge clk_i);
    addr_i = a; wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    if (a == 8'hA0) m_data = d;
    if (a == 8'hA4) begin
      check({req, "/R12 pulse"}, {31'd0, req_pulse_o}, {31'd0, d[31]});
      if (d[31]) begin
        if (d[30]) m_unk = 1'b0;
        else if (d[29:26] != 0 || d[15:12] != 0 || d[25:20] != 6'd1 || d[17:16] > 2'd1) m_unk = 1'b1;
        else begin
          m_data = freq_of(d[17:16], d[11:0]);
          m_unk  = !freq_of(d[17:16], d[11:0])[32];
        end
      end
      check({req, " unknown"}, {31'd0, unknown_o}, {31'd0, m_unk});
    end
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    check(req, rd_data_o, exp);
  endtask

  initial begin
    repeat (2000000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20131031);
    repeat (3) @(negedge clk_i);
    check("R1 rd_data", rd_data_o, 0);
    check("R1 pulse", {31'd0, req_pulse_o}, 0);
    check("R1 unknown", {31'd0, unknown_o}, 0);
    rst_ni = 1'b1;
    bus_rd(8'hA0, 0, "R1 data reset");

    bus_wr(8'hA0, 32'hDEADBEEF, "R2");
    bus_rd(8'hA0, 32'hDEADBEEF, "R2 readback");
    bus_rd(8'hA8, 1, "R3 status");
    bus_rd(8'hA4, 0, "R3 command");
    bus_rd(8'h10, 0, "R3 unmapped");
    bus_wr(8'hA4, mk_cmd(0, 0, 0, 1, 0, 0, 2), "R4 no start");
    bus_rd(8'hA0, m_data, "R4 data kept");
    bus_wr(8'hA4, mk_cmd(1, 1, 0, 1, 0, 0, 2), "R5 cfg write");
    bus_rd(8'hA0, m_data, "R5 data kept");
    bus_wr(8'hA4, mk_cmd(1, 0, 0, 2, 0, 0, 0), "R6 bad fn");
    bus_rd(8'hA0, m_data, "R6 data kept");
    bus_wr(8'hA4, mk_cmd(1, 0, 0, 1, 0, 0, 2), "R7 site0 dev2");
    bus_rd(8'hA0, 32'd24000000, "R7 24M readback R11");
    bus_wr(8'hA4, mk_cmd(1, 0, 0, 1, 0, 0, 3), "R7 site0 dev3");
    bus_rd(8'hA0, 0, "R7 unmapped dev");
    bus_wr(8'hA0, 32'h12345678, "R2");
    bus_wr(8'hA4, mk_cmd(1, 0, 0, 1, 2'd2, 0, 0), "R9 site2");
    bus_rd(8'hA0, 32'h12345678, "R9 data kept");
    bus_wr(8'hA4, mk_cmd(1, 0, 0, 1, 1, 0, 6), "R8 site1 dev6");
    bus_rd(8'hA0, 32'd35000000, "R8 35M");
    bus_wr(8'hA4, mk_cmd(1, 0, 0, 1, 1, 0, 9), "R8 site1 dev9");
    bus_rd(8'hA0, 0, "R8 unmapped dev");
    bus_wr(8'hA0, 32'h0BADF00D, "R2");
    bus_wr(8'hA8, 32'hFFFFFFFF, "R10 status write");
    bus_wr(8'h3C, 32'hFFFFFFFF, "R10 unmapped write");
    bus_rd(8'hA0, 32'h0BADF00D, "R10 data kept");
    bus_rd(8'hA8, 1, "R10 status still 1");

    for (int i = 0; i < 400; i++) begin
      int unsigned op = $urandom_range(0, 9);
      if (op < 5) begin
        logic [3:0] ctl = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'd0;
        logic [3:0] pos = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'd0;
        logic [5:0] fn  = ($urandom_range(0, 7) == 0) ? 6'($urandom) : 6'd1;
        bus_wr(8'hA4, mk_cmd($urandom_range(0, 5) != 0, $urandom_range(0, 5) == 0, ctl, fn,
               2'($urandom), pos, 12'($urandom_range(0, 10))), "R7/R8/R9 random cmd");
      end else if (op == 5) bus_wr(8'hA0, $urandom, "R2 random");
      else if (op == 6) bus_rd(8'hA8, 1, "R3 random status");
      else if (op == 7) bus_rd(8'hA4, 0, "R3 random command");
      else bus_rd(8'hA0, m_data, "R11 random data read");
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule